// File: doc/BRIEF.md
# NCO Complex Frequency Mixer

This block shifts a stream of 16-bit samples in frequency. It multiplies each sample by a rotating phasor taken from a numerically controlled oscillator and delivers one I/Q result per clock. The oscillator phase is a 48-bit accumulator that advances by a signed tuning word on every clock, so the tuning range spans minus half to plus half of the sample rate. An 18-bit signed phase offset, whose full range covers one turn, is added before a fixed sine table is read. A phase-clear input restarts the accumulator, which lets several copies of the block run in phase lock.

The input can be real or complex. Converters narrower than 16 bits are placed in the top bits of the sample field, and their unused low bits are forced to zero. Besides full oscillator mixing, the block has three cheap modes that use no table and no multiplier: a quarter-rate shift, a half-rate shift and a straight pass. These modes only swap and negate the I and Q values, so their results are exact. Oscillator products are rounded to 16 bits and clip at full scale instead of wrapping.

Top module: `nco_mixer`

## Requirements
- R1: While reset is high, and for the four samples that follow its release, both outputs are zero. The accumulator and the step counter restart at zero.
- R2: The result for a sample presented in clock cycle n appears on the outputs during cycle n+4 and is held for exactly that one cycle.
- R3: The phase used for a sample is the accumulator value in its cycle. The accumulator then becomes the old value plus `freq_word`, modulo 2^48. The table index is bits [17:10] of ((accumulator bits [47:30]) + `phase_off`) mod 2^18.
- R4: In mode 2'b00 the table holds T[k] = round(32767·sin(2πk/256)). With S = T[idx] and C = T[(idx+64) mod 256], the outputs are out_i = clip(floor((xi·C − xq·S + 2^14)/2^15)) and out_q = clip(floor((xi·S + xq·C + 2^14)/2^15)).
- R5: When `phase_rst` is high in a cycle, that cycle's sample still uses the current phase. The next sample uses accumulator 0 and step 0.
- R6: With `iq_mode` = 0 the input is real: `in_q` is ignored and taken as zero. With `iq_mode` = 1 both inputs are used.
- R7: With CONV_W = 14, bits [1:0] of `in_i` and `in_q` are ignored (treated as zero) in every mode.
- R8: In mode 2'b01 (quarter-rate shift), a sample with step s mod 4 = 0, 1, 2, 3 gives (xi,xq), (xq,−xi), (−xi,−xq), (−xq,xi). The step counts clock cycles since the last reset or phase clear.
- R9: In mode 2'b10 (half-rate shift), a sample with an even step gives (xi,xq) and one with an odd step gives (−xi,−xq).
- R10: In mode 2'b11 the output equals the masked input with no rotation.
- R11: Negating −32768 yields +32767. Oscillator results outside [−32768, 32767] clip to the nearer limit.
- R12: Mode, input type, tuning word and offset are taken per sample, so a change takes effect from the very sample presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst | input | 1 | Synchronous reset, active high |
| mix_mode | input | 2 | 00 oscillator, 01 quarter-rate, 10 half-rate, 11 pass |
| iq_mode | input | 1 | 1 complex input, 0 real input |
| phase_rst | input | 1 | Clears accumulator and step counter after this sample |
| freq_word | input | 48 | Signed tuning word added every clock |
| phase_off | input | 18 | Signed phase offset, full range is one turn |
| in_i | input | 16 | Input I sample, two's complement |
| in_q | input | 16 | Input Q sample, two's complement |
| out_i | output | 16 | Output I sample, registered |
| out_q | output | 16 | Output Q sample, registered |

## Verification
The bench builds the block with a 14-bit converter width, so the masking of the two low input bits can be seen in every mode. All other parameters keep their defaults: a 48-bit accumulator, an 18-bit offset and a 256-entry table. With these values, tuning words at exactly Fs/4 and −Fs/2 land on exact table points, while random words and offsets reach every table index. A 45-degree offset with opposite full-scale inputs drives the rounded product past full scale, which exercises the clipping path.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;
  typedef enum logic [1:0] {
    MIX_NCO  = 2'd0,
    MIX_QTR  = 2'd1,
    MIX_HALF = 2'd2,
    MIX_PASS = 2'd3
  } mix_mode_e;
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int FW = 48,
  parameter int PW = 18,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phase_rst,
  input  logic [FW-1:0] freq_word,
  input  logic [PW-1:0] phase_off,
  output logic [AW-1:0] addr_q,
  output logic [1:0]    step_q
);
  logic [FW-1:0] acc;
  logic [1:0]    step;
  logic [PW-1:0] phase_sum;

  // offset added at offset resolution, then truncated to table index
  assign phase_sum = acc[FW-1 -: PW] + phase_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      step   <= '0;
      addr_q <= '0;
      step_q <= '0;
    end else begin
      addr_q <= phase_sum[PW-1 -: AW];
      step_q <= step;
      if (phase_rst) begin
        acc  <= '0;
        step <= '0;
      end else begin
        acc  <= acc + freq_word;
        step <= step + 2'd1;
      end
    end
  end

  // R3: accumulator advances by the tuning word of the previous cycle
  a_r3_acc_advance: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(phase_rst)) |-> (acc == $past(acc) + $past(freq_word)));

  // R5: a phase clear leaves accumulator and step at zero
  a_r5_phase_clear: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(phase_rst)) |-> (acc == '0 && step == 2'd0));
endmodule

// File: rtl/nco_sin_rom.sv
module nco_sin_rom #(
  parameter int AW = 8,
  parameter int VW = 16
) (
  input  logic                 clk,
  input  logic [AW-1:0]        addr,
  output logic signed [VW-1:0] sin_o,
  output logic signed [VW-1:0] cos_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] QTURN = AW'(DEPTH / 4);
  localparam real TWO_PI = 6.28318530717958647692;
  localparam real AMP = real'((1 << (VW - 1)) - 1);

  logic signed [VW-1:0] tbl [DEPTH];
  logic [AW-1:0] addr_c;

  initial begin
    real ang;
    for (int k = 0; k < DEPTH; k++) begin
      ang = AMP * $sin(TWO_PI * real'(k) / real'(DEPTH));
      tbl[k] = VW'($rtoi(ang >= 0.0 ? ang + 0.5 : ang - 0.5));
    end
  end

  assign addr_c = addr + QTURN;

  // two registered read ports, block-RAM style
  always_ff @(posedge clk) begin
    sin_o <= tbl[addr];
    cos_o <= tbl[addr_c];
  end
endmodule

// File: rtl/nco_cmul.sv
module nco_cmul
  import nco_mix_pkg::*;
#(
  parameter int DW = 16,
  parameter int VW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  mix_mode_e            mode_i,
  input  logic [1:0]           step_i,
  input  logic signed [DW-1:0] xi,
  input  logic signed [DW-1:0] xq,
  input  logic signed [VW-1:0] cos_i,
  input  logic signed [VW-1:0] sin_i,
  output logic signed [DW-1:0] yi,
  output logic signed [DW-1:0] yq
);
  localparam int SUMW = DW + VW + 1;
  localparam int SHIFT = VW - 1;
  localparam logic signed [SUMW-1:0] RND  = SUMW'(1) <<< (SHIFT - 1);
  localparam logic signed [SUMW-1:0] MAXS = (SUMW'(1) <<< (DW - 1)) - SUMW'(1);
  localparam logic signed [SUMW-1:0] MINS = -(SUMW'(1) <<< (DW - 1));
  localparam logic signed [DW-1:0]   MAXD = MAXS[DW-1:0];
  localparam logic signed [DW-1:0]   MIND = MINS[DW-1:0];

  logic signed [SUMW-1:0] sum_i, sum_q;
  logic signed [DW-1:0]   fix_i, fix_q, rot_i, rot_q;
  mix_mode_e              mode_a;

  function automatic logic signed [SUMW-1:0] prod(input logic signed [DW-1:0] a,
                                                  input logic signed [VW-1:0] b);
    return SUMW'(a) * SUMW'(b);
  endfunction

  function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] a);
    return (a == MIND) ? MAXD : -a;
  endfunction

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [SUMW-1:0] s);
    logic signed [SUMW-1:0] r;
    r = (s + RND) >>> SHIFT;
    if (r > MAXS)      return MAXD;
    else if (r < MINS) return MIND;
    else               return r[DW-1:0];
  endfunction

  always_comb begin
    rot_i = xi;
    rot_q = xq;
    unique case (mode_i)
      MIX_QTR: begin
        unique case (step_i)
          2'd0: begin rot_i = xi;          rot_q = xq;          end
          2'd1: begin rot_i = xq;          rot_q = neg_sat(xi); end
          2'd2: begin rot_i = neg_sat(xi); rot_q = neg_sat(xq); end
          2'd3: begin rot_i = neg_sat(xq); rot_q = xi;          end
        endcase
      end
      MIX_HALF: begin
        if (step_i[0]) begin
          rot_i = neg_sat(xi);
          rot_q = neg_sat(xq);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_i  <= '0;
      sum_q  <= '0;
      fix_i  <= '0;
      fix_q  <= '0;
      mode_a <= MIX_NCO;
      yi     <= '0;
      yq     <= '0;
    end else begin
      sum_i  <= prod(xi, cos_i) - prod(xq, sin_i);
      sum_q  <= prod(xi, sin_i) + prod(xq, cos_i);
      fix_i  <= rot_i;
      fix_q  <= rot_q;
      mode_a <= mode_i;
      if (mode_a == MIX_NCO) begin
        yi <= rnd_sat(sum_i);
        yq <= rnd_sat(sum_q);
      end else begin
        yi <= fix_i;
        yq <= fix_q;
      end
    end
  end

  // R10: pass mode forwards the sample unchanged
  a_r10_pass_exact: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MIX_PASS) |=> (fix_i == $past(xi) && fix_q == $past(xq)));

  // R9: half-rate mode leaves even steps untouched
  a_r9_half_even: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MIX_HALF && !step_i[0]) |=> (fix_i == $past(xi) && fix_q == $past(xq)));

  // R11: an oversized positive sum clips to full scale
  a_r11_clip_high: assert property (@(posedge clk) disable iff (rst)
    (mode_a == MIX_NCO && sum_i > (MAXS <<< SHIFT)) |=> (yi == MAXD));

  // R11: an oversized negative sum clips to negative full scale
  a_r11_clip_low: assert property (@(posedge clk) disable iff (rst)
    (mode_a == MIX_NCO && sum_q < ((MINS - SUMW'(1)) <<< SHIFT)) |=> (yq == MIND));
endmodule

// File: rtl/nco_mixer.sv
module nco_mixer
  import nco_mix_pkg::*;
#(
  parameter int DW     = 16,
  parameter int CONV_W = 16,
  parameter int FW     = 48,
  parameter int PW     = 18,
  parameter int AW     = 8,
  parameter int VW     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mix_mode,
  input  logic                 iq_mode,
  input  logic                 phase_rst,
  input  logic [FW-1:0]        freq_word,
  input  logic [PW-1:0]        phase_off,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int LOWB = DW - CONV_W;
  localparam logic [DW-1:0] KEEP = ~DW'((64'd1 << LOWB) - 64'd1);

  logic [AW-1:0]        addr1;
  logic [1:0]           step1, step2;
  logic signed [DW-1:0] xi1, xq1, xi2, xq2;
  logic signed [VW-1:0] sin2, cos2;
  mix_mode_e            mode1, mode2;

  nco_phase_acc #(.FW(FW), .PW(PW), .AW(AW)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .phase_rst (phase_rst),
    .freq_word (freq_word),
    .phase_off (phase_off),
    .addr_q    (addr1),
    .step_q    (step1)
  );

  nco_sin_rom #(.AW(AW), .VW(VW)) u_rom (
    .clk   (clk),
    .addr  (addr1),
    .sin_o (sin2),
    .cos_o (cos2)
  );

  // stage 1: input masking and real/complex select; stage 2: align with table read
  always_ff @(posedge clk) begin
    if (rst) begin
      xi1   <= '0;
      xq1   <= '0;
      mode1 <= MIX_NCO;
      xi2   <= '0;
      xq2   <= '0;
      mode2 <= MIX_NCO;
      step2 <= '0;
    end else begin
      xi1   <= in_i & KEEP;
      xq1   <= iq_mode ? (in_q & KEEP) : '0;
      mode1 <= mix_mode_e'(mix_mode);
      xi2   <= xi1;
      xq2   <= xq1;
      mode2 <= mode1;
      step2 <= step1;
    end
  end

  nco_cmul #(.DW(DW), .VW(VW)) u_mul (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode2),
    .step_i (step2),
    .xi     (xi2),
    .xq     (xq2),
    .cos_i  (cos2),
    .sin_i  (sin2),
    .yi     (out_i),
    .yq     (out_q)
  );

  // R6: a real input enters the pipeline with a zero Q part
  a_r6_real_zero: assert property (@(posedge clk) disable iff (rst)
    !iq_mode |=> (xq1 == '0));

  // R7: stripped low bits never reach the pipeline
  a_r7_low_masked: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((xi1 & ~KEEP) == '0 && (xq1 & ~KEEP) == '0));
endmodule

// File: tb/nco_mixer_tb.sv
module nco_mixer_tb;
  localparam int DW = 16;
  localparam int CONV_W = 14;
  localparam logic [15:0] KEEP = 16'hFFFC;
  localparam real TWO_PI = 6.28318530717958647692;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mix_mode = 2'd0;
  logic iq_mode = 1'b1;
  logic phase_rst = 1'b0;
  logic [47:0] freq_word = '0;
  logic [17:0] phase_off = '0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic signed [15:0] out_i, out_q;

  int total = 0;
  int bad = 0;
  int k = 0;
  logic [47:0] ba = '0;
  logic [1:0]  bs = '0;
  longint tbl [256];
  logic signed [15:0] exp_i [8];
  logic signed [15:0] exp_q [8];
  string exp_t [8];

  nco_mixer #(.CONV_W(CONV_W)) u_dut (
    .clk(clk), .rst(rst), .mix_mode(mix_mode), .iq_mode(iq_mode),
    .phase_rst(phase_rst), .freq_word(freq_word), .phase_off(phase_off),
    .in_i(in_i), .in_q(in_q), .out_i(out_i), .out_q(out_q)
  );

  always #4 clk = ~clk;

  function automatic logic signed [15:0] neg16(input logic signed [15:0] a);
    return (a == -16'sd32768) ? 16'sd32767 : -a;
  endfunction

  function automatic logic signed [15:0] clip16(input longint v);
    if (v > 32767) return 16'sd32767;
    if (v < -32768) return -16'sd32768;
    return 16'(v);
  endfunction

  task automatic check(input logic signed [15:0] gi, gq, ei, eq, input string tag);
    total++;
    if (gi !== ei || gq !== eq) begin
      bad++;
      $display("FAIL %s: got (%0d,%0d) expected (%0d,%0d) at sample %0d", tag, gi, gq, ei, eq, k);
    end
  endtask

  // present one sample at a falling edge; the result for sample k-4 is visible now
  task automatic step(input logic signed [15:0] i, q, input logic [47:0] f,
                      input logic [17:0] off, input logic [1:0] md,
                      input logic iqm, input logic prst, input string tag);
    logic signed [15:0] mi, mq, ri, rq;
    logic [17:0] psum;
    logic [7:0] idx;
    longint s, c, li, lq;
    check(out_i, out_q, exp_i[(k + 4) % 8], exp_q[(k + 4) % 8], exp_t[(k + 4) % 8]);
    rst = 1'b0;
    in_i = i; in_q = q; freq_word = f; phase_off = off;
    mix_mode = md; iq_mode = iqm; phase_rst = prst;
    mi = i & KEEP;
    mq = iqm ? (q & KEEP) : 16'sd0;
    ri = mi; rq = mq;
    case (md)
      2'd0: begin
        psum = ba[47:30] + off;
        idx = psum[17:10];
        s = tbl[idx];
        c = tbl[8'(idx + 8'd64)];
        li = longint'(mi); lq = longint'(mq);
        ri = clip16((li * c - lq * s + 16384) >>> 15);
        rq = clip16((li * s + lq * c + 16384) >>> 15);
      end
      2'd1: case (bs)
        2'd1: begin ri = mq; rq = neg16(mi); end
        2'd2: begin ri = neg16(mi); rq = neg16(mq); end
        2'd3: begin ri = neg16(mq); rq = mi; end
        default: ;
      endcase
      2'd2: if (bs[0]) begin ri = neg16(mi); rq = neg16(mq); end
      default: ;
    endcase
    exp_i[k % 8] = ri; exp_q[k % 8] = rq; exp_t[k % 8] = tag;
    if (prst) begin ba = '0; bs = '0; end
    else begin ba = ba + f; bs = bs + 2'd1; end
    k++;
    @(negedge clk);
  endtask

  task automatic rnd_run(input int n, input logic [47:0] f, input logic [1:0] md,
                         input logic iqm, input logic rand_off, input string tag);
    for (int j = 0; j < n; j++)
      step(16'($urandom), 16'($urandom), f, rand_off ? 18'($urandom) : 18'd0,
           md, iqm, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    real a;
    seed = $urandom(20240);
    for (int j = 0; j < 256; j++) begin
      a = 32767.0 * $sin(TWO_PI * real'(j) / 256.0);
      tbl[j] = longint'($rtoi(a >= 0.0 ? a + 0.5 : a - 0.5));
    end
    for (int j = 0; j < 8; j++) begin exp_i[j] = '0; exp_q[j] = '0; exp_t[j] = "R1"; end

    // R1: reset state with busy inputs
    in_i = 16'sd1234; in_q = -16'sd999; freq_word = 48'h123456789ABC;
    repeat (5) @(negedge clk);
    check(out_i, out_q, 16'sd0, 16'sd0, "R1");
    in_i = '0; in_q = '0; freq_word = '0;
    // reset released inside the first step; first four results are zero (R1)

    // R2: an impulse in pass mode arrives exactly four cycles later
    step(16'sd4000, -16'sd800, '0, '0, 2'd3, 1'b1, 1'b0, "R2");
    for (int j = 0; j < 6; j++) step('0, '0, '0, '0, 2'd3, 1'b1, 1'b0, "R2");

    // R4 / R3: oscillator at several tuning words, complex data
    step('0, '0, '0, '0, 2'd0, 1'b1, 1'b1, "R5");
    rnd_run(24, 48'h0, 2'd0, 1'b1, 1'b0, "R4");
    rnd_run(24, 48'h4000_0000_0000, 2'd0, 1'b1, 1'b0, "R4");
    rnd_run(24, 48'h8000_0000_0000, 2'd0, 1'b1, 1'b0, "R4");
    rnd_run(24, 48'h0123_4567_89AB, 2'd0, 1'b1, 1'b0, "R3");
    rnd_run(24, 48'hFF00_0000_1234, 2'd0, 1'b1, 1'b0, "R3");
    for (int j = 0; j < 40; j++)
      step(16'($urandom), 16'($urandom), {$urandom, 16'($urandom)}, 18'($urandom),
           2'd0, 1'b1, 1'b0, "R12");
    rnd_run(24, 48'h1357_9BDF_0246, 2'd0, 1'b1, 1'b1, "R3");

    // R6: real input with random Q that must be ignored
    rnd_run(24, 48'h0800_0000_0000, 2'd0, 1'b0, 1'b1, "R6");
    rnd_run(8, 48'h0, 2'd3, 1'b0, 1'b0, "R6");

    // R11: 45 degree rotation of opposite full-scale values clips
    step('0, '0, '0, '0, 2'd0, 1'b1, 1'b1, "R5");
    for (int j = 0; j < 4; j++)
      step(16'sd32767, -16'sd32768, 48'h0, 18'd32768, 2'd0, 1'b1, 1'b0, "R11");
    for (int j = 0; j < 4; j++)
      step(-16'sd32768, 16'sd32767, 48'h0, 18'd32768, 2'd0, 1'b1, 1'b0, "R11");

    // R5: phase clears in the middle of a running stream
    rnd_run(10, 48'h2345_6789_ABCD, 2'd0, 1'b1, 1'b0, "R5");
    step(16'sd10000, 16'sd5000, 48'h2345_6789_ABCD, '0, 2'd0, 1'b1, 1'b1, "R5");
    rnd_run(10, 48'h2345_6789_ABCD, 2'd0, 1'b1, 1'b0, "R5");
    step(16'sd100, -16'sd200, '0, '0, 2'd1, 1'b1, 1'b1, "R5");
    rnd_run(6, '0, 2'd1, 1'b1, 1'b0, "R5");

    // R8 / R9 / R10: table-free modes, random and extreme data
    rnd_run(20, '0, 2'd1, 1'b1, 1'b0, "R8");
    for (int j = 0; j < 8; j++)
      step(-16'sd32768, -16'sd32768, '0, '0, 2'd1, 1'b1, 1'b0, "R11");
    rnd_run(20, '0, 2'd2, 1'b1, 1'b0, "R9");
    for (int j = 0; j < 4; j++)
      step(-16'sd32768, 16'sd32767, '0, '0, 2'd2, 1'b1, 1'b0, "R11");
    rnd_run(20, '0, 2'd3, 1'b1, 1'b0, "R10");

    // R12: mode changes take effect on the very sample
    for (int j = 0; j < 16; j++)
      step(16'($urandom), 16'($urandom), 48'h0A00_0000_0000, 18'($urandom),
           2'($urandom), 1'($urandom), 1'b0, "R12");

    // R7: values living only in the two stripped bits vanish
    step(16'sd3, 16'sd2, '0, '0, 2'd3, 1'b1, 1'b0, "R7");
    step(16'sd1, 16'sd3, '0, '0, 2'd1, 1'b1, 1'b0, "R7");
    step(-16'sd1, 16'sd3, 48'h0, 18'd5000, 2'd0, 1'b1, 1'b0, "R7");
    rnd_run(12, 48'h3000_0000_0001, 2'd0, 1'b1, 1'b1, "R7");

    for (int j = 0; j < 5; j++) step('0, '0, '0, '0, 2'd3, 1'b1, 1'b0, "R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule